// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block decides, for a five-stage in-order pipeline, where each of the two ALU operands of the instruction in execute should come from. The instruction in execute may read a register that an older instruction has not yet written back. The block compares the execute-stage source register numbers against the destination numbers in the two later pipeline registers, which feed the memory stage and the write-back stage. When a match is found, it steers the operand mux to the newer result instead of the register-file value. When both later stages hold a result for the same register, the younger one in the memory-stage register wins. Register 0 always reads as zero, so it never takes part in a match. A producer counts only when its write enable is set, so stores and branches are never bypass sources.

A load sitting in the execute-stage register cannot supply its data in time for the instruction directly behind it in decode. In that case the block raises a stall, which freezes the PC and the fetch/decode register, and a bubble, which clears the write controls entering execute. Both are raised in the same cycle. One cycle later the load has moved on, and its data reaches the consumer through the write-back bypass. The register file writes in the first half of a cycle and reads in the second half, so a result in write-back needs no path toward decode. With reads only in decode and writes only in write-back, only read-after-write dependences arise. The selection and interlock logic is combinational. The clock and reset are used only by the checking properties.

Top module: `fwd_hazard_unit`

## Requirements
- R1: If the memory-stage register has its write enable set and a nonzero destination equal to an execute source, that operand select is 2'b10 (memory-stage result).
- R2: If only the write-back register matches an execute source (write enable set, nonzero destination), that operand select is 2'b01 (write-back result).
- R3: If both later stages match the same execute source, the select is 2'b10, so the younger result has priority.
- R4: With no match, the operand select is 2'b00 (register-file value).
- R5: A source or destination number of 0 never produces a forward or a stall.
- R6: A stage with its write enable clear is never a forward or stall source, even when its destination matches.
- R7: If the execute-stage register holds a load with its write enable set and a nonzero destination equal to either decode source, stall and bubble are both 1 in that same cycle.
- R8: A matching producer in the execute-stage register that is not a load causes no stall.
- R9: The bubble output equals the stall output in every cycle.
- R10: A match between the write-back destination and a decode source never causes a stall.
- R11: The two operand selects are decided independently, so each may come from a different source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the checking properties |
| rst_n | input | 1 | Active-low reset that disables the properties |
| ex_rs1 | input | AW | First source register of the instruction in execute |
| ex_rs2 | input | AW | Second source register of the instruction in execute |
| id_rs1 | input | AW | First source register of the instruction in decode |
| id_rs2 | input | AW | Second source register of the instruction in decode |
| idex_rd | input | AW | Destination held in the execute-stage register |
| idex_we | input | 1 | Register write enable in the execute-stage register |
| idex_load | input | 1 | Load flag in the execute-stage register |
| exmem_rd | input | AW | Destination held in the memory-stage register |
| exmem_we | input | 1 | Register write enable in the memory-stage register |
| memwb_rd | input | AW | Destination held in the write-back register |
| memwb_we | input | 1 | Register write enable in the write-back register |
| fwd_a_sel | output | 2 | Operand A source: 00 register file, 01 write-back, 10 memory stage |
| fwd_b_sel | output | 2 | Operand B source, same encoding |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Clear write controls into execute |

## Verification
On every cycle the properties check several conditions. A memory-stage select must be backed by an enabled, nonzero, matching producer, and a write-back select must have a matching write-back producer. Register 0 must always select the register file. Any stall must come from an enabled load whose destination matches a decode source, and the bubble must follow the stall. The properties cannot show whether the correct source was chosen. The bench's reference model shows this by comparing every output each cycle, over directed cases and a long stretch of random register numbers drawn from a small range. That comparison covers several behaviours: younger-over-older priority, the lack of a stall for non-load producers and for write-back matches, and independent choices for the two operands.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        SEL_RF    = 2'b00,
        SEL_MEMWB = 2'b01,
        SEL_EXMEM = 2'b10
    } opsel_e;
endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] exmem_rd,
    input  logic          exmem_we,
    input  logic [AW-1:0] memwb_rd,
    input  logic          memwb_we,
    output opsel_e        sel
);
    logic hit_em;
    logic hit_mw;

    always_comb begin
        hit_em = exmem_we && (exmem_rd != '0) && (exmem_rd == src);
        hit_mw = memwb_we && (memwb_rd != '0) && (memwb_rd == src);
    end

    // younger producer first
    always_comb begin
        if (hit_em)      sel = SEL_EXMEM;
        else if (hit_mw) sel = SEL_MEMWB;
        else             sel = SEL_RF;
    end

    // R1 / R6: a memory-stage pick needs an enabled matching producer
    a_r1_exmem_backed: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_EXMEM) |-> (exmem_we && exmem_rd == src));

    // R2: a write-back pick needs an enabled matching producer
    a_r2_memwb_backed: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_MEMWB) |-> (memwb_we && memwb_rd == src));

    // R5: register 0 reads the register file
    a_r5_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (sel == SEL_RF));
endmodule

// File: rtl/fwd_load_use.sv
module fwd_load_use #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic [AW-1:0] idex_rd,
    input  logic          idex_we,
    input  logic          idex_load,
    output logic          hold
);
    logic dest_live;
    logic uses_dest;

    always_comb begin
        dest_live = idex_we && idex_load && (idex_rd != '0);
        uses_dest = (id_rs1 == idex_rd) || (id_rs2 == idex_rd);
        hold      = dest_live && uses_dest;
    end

    // R7 / R8 / R6: only an enabled load can freeze the front end
    a_r7_hold_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (idex_load && idex_we));

    // R5 / R10: a hold always names a live nonzero decode source
    a_r10_hold_source: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (idex_rd != '0 && (id_rs1 == idex_rd || id_rs2 == idex_rd)));
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic [AW-1:0] idex_rd,
    input  logic          idex_we,
    input  logic          idex_load,
    input  logic [AW-1:0] exmem_rd,
    input  logic          exmem_we,
    input  logic [AW-1:0] memwb_rd,
    input  logic          memwb_we,
    output logic [1:0]    fwd_a_sel,
    output logic [1:0]    fwd_b_sel,
    output logic          stall,
    output logic          bubble
);
    localparam int NOPS = 2;

    logic [AW-1:0] src   [NOPS];
    opsel_e        pick  [NOPS];
    logic          hold;

    assign src[0] = ex_rs1;
    assign src[1] = ex_rs2;

    for (genvar g = 0; g < NOPS; g++) begin : g_opnd
        fwd_operand_sel #(.AW(AW)) u_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (src[g]),
            .exmem_rd (exmem_rd),
            .exmem_we (exmem_we),
            .memwb_rd (memwb_rd),
            .memwb_we (memwb_we),
            .sel      (pick[g])
        );
    end

    fwd_load_use #(.AW(AW)) u_ilk (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_rs1    (id_rs1),
        .id_rs2    (id_rs2),
        .idex_rd   (idex_rd),
        .idex_we   (idex_we),
        .idex_load (idex_load),
        .hold      (hold)
    );

    assign fwd_a_sel = pick[0];
    assign fwd_b_sel = pick[1];
    assign stall     = hold;
    assign bubble    = hold;

    // R9: bubble and stall travel together
    a_r9_bubble_with_stall: assert property (@(posedge clk) disable iff (!rst_n)
        bubble == stall);

    // R11: operand B obeys the same backing rule as operand A
    a_r11_b_exmem_backed: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_b_sel == 2'b10) |-> (exmem_we && exmem_rd == ex_rs2 && ex_rs2 != '0));
endmodule

// File: tb/fwd_hazard_unit_test.sv
module fwd_hazard_unit_test;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] ex_rs1 = '0, ex_rs2 = '0, id_rs1 = '0, id_rs2 = '0;
    logic [AW-1:0] idex_rd = '0, exmem_rd = '0, memwb_rd = '0;
    logic idex_we = 1'b0, idex_load = 1'b0, exmem_we = 1'b0, memwb_we = 1'b0;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic stall, bubble;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fwd_hazard_unit #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .idex_rd(idex_rd), .idex_we(idex_we), .idex_load(idex_load),
        .exmem_rd(exmem_rd), .exmem_we(exmem_we),
        .memwb_rd(memwb_rd), .memwb_we(memwb_we),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .stall(stall), .bubble(bubble)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference: 2 = memory stage, 1 = write-back, 0 = register file
    function automatic int ref_sel(int s, int emr, bit emw, int mwr, bit mww);
        if (s == 0) return 0;
        if (emw && emr == s) return 2;
        if (mww && mwr == s) return 1;
        return 0;
    endfunction

    function automatic string sel_tag(int s, int emr, bit emw, int mwr, bit mww);
        if (s == 0) return "R5";
        if (emw && emr == s && mww && mwr == s) return "R3";
        if (emw && emr == s) return "R1";
        if (mww && mwr == s) return "R2";
        if (emr == s || mwr == s) return "R6";
        return "R4";
    endfunction

    function automatic int ref_stall();
        if (idex_load && idex_we && idex_rd != 0 &&
            (idex_rd == id_rs1 || idex_rd == id_rs2)) return 1;
        return 0;
    endfunction

    function automatic string stall_tag();
        if (ref_stall() == 1) return "R7";
        if (idex_rd == 0) return "R5";
        if (idex_we && (idex_rd == id_rs1 || idex_rd == id_rs2)) return "R8";
        if (memwb_we && memwb_rd != 0 && (memwb_rd == id_rs1 || memwb_rd == id_rs2)) return "R10";
        return "R6";
    endfunction

    task automatic compare_all();
        check(sel_tag(ex_rs1, exmem_rd, exmem_we, memwb_rd, memwb_we),
              fwd_a_sel, ref_sel(ex_rs1, exmem_rd, exmem_we, memwb_rd, memwb_we));
        check(sel_tag(ex_rs2, exmem_rd, exmem_we, memwb_rd, memwb_we),
              fwd_b_sel, ref_sel(ex_rs2, exmem_rd, exmem_we, memwb_rd, memwb_we));
        check(stall_tag(), stall, ref_stall());
        check("R9", bubble, stall);
    endtask

    task automatic put(int a, int b, int ia, int ib, int xr, bit xw, bit xl,
                       int er, bit ew, int wr, bit ww);
        @(posedge clk); #1;
        ex_rs1 = AW'(a); ex_rs2 = AW'(b); id_rs1 = AW'(ia); id_rs2 = AW'(ib);
        idex_rd = AW'(xr); idex_we = xw; idex_load = xl;
        exmem_rd = AW'(er); exmem_we = ew; memwb_rd = AW'(wr); memwb_we = ww;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4", fwd_a_sel, 0);
        check("R4", fwd_b_sel, 0);
        check("R7", stall, 0);
        rst_n = 1'b1;
        // R1: memory-stage hit on A
        put(3, 4, 0, 0, 0, 0, 0, 3, 1, 0, 0);
        check("R1", fwd_a_sel, 2);
        // R2: write-back hit on B
        put(3, 4, 0, 0, 0, 0, 0, 0, 0, 4, 1);
        check("R2", fwd_b_sel, 1);
        // R3: both hit A, younger wins
        put(7, 1, 0, 0, 0, 0, 0, 7, 1, 7, 1);
        check("R3", fwd_a_sel, 2);
        // R5: register 0 everywhere
        put(0, 0, 0, 0, 0, 1, 1, 0, 1, 0, 1);
        check("R5", fwd_a_sel, 0);
        check("R5", stall, 0);
        // R6: write enables clear
        put(6, 6, 6, 0, 6, 0, 1, 6, 0, 6, 0);
        check("R6", fwd_a_sel, 0);
        check("R6", stall, 0);
        // R7: load-use on second decode source
        put(1, 2, 9, 12, 12, 1, 1, 0, 0, 0, 0);
        check("R7", stall, 1);
        check("R7", bubble, 1);
        // R8: ALU producer matching decode
        put(1, 2, 12, 0, 12, 1, 0, 0, 0, 0, 0);
        check("R8", stall, 0);
        // R10: write-back matching decode
        put(1, 2, 15, 15, 0, 0, 0, 0, 0, 15, 1);
        check("R10", stall, 0);
        // R11: A from memory stage, B from write-back
        put(5, 8, 0, 0, 0, 0, 0, 5, 1, 8, 1);
        check("R11", fwd_a_sel, 2);
        check("R11", fwd_b_sel, 1);
        // random sweep over a narrow register range
        for (int i = 0; i < 3000; i++) begin
            put($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom),
                1'($urandom), $urandom_range(0, 3), 1'($urandom),
                $urandom_range(0, 3), 1'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule